// File: doc/BRIEF.md
# Inter-Core Mailbox Doorbell Unit

Each core owns one mailbox of independent doorbell bits. Any core rings a doorbell by writing ones to the set window of the target core's mailbox. The owning core reads its mailbox through the clear window and acknowledges the bits it has handled by writing ones back to that same window. While a core's mailbox holds any set bit and the core has enabled it, that core's interrupt line is asserted.

The unit has one write port per requester, so several cores can ring doorbells in the same cycle. It also has one read port with a single cycle of latency, and one registered interrupt output per core. Mailboxes are placed 16 bytes apart in both windows. The small per-core control registers hold only the interrupt enable. With the default parameters the control register of core n is at 0x00 + 4n, its set window at 0x40 + 16n and its clear window at 0x80 + 16n. The data width is 32 bits.

Top module: `mbox_doorbell`

## Requirements
- R1: A write on any port to address 0x40 + 16n ORs its data into mailbox n on the next clock edge. Bits written as zero, and all other mailboxes, are left as they were.
- R2: A write to address 0x80 + 16n clears, on the next edge, every bit of mailbox n that is written as one. All other bits stay as they were.
- R3: A read issued with rd_en at edge k places its result on rd_data after edge k. The result holds until the next read. Reading 0x80 + 16n returns mailbox n. Reading 0x00 + 4n returns the enable in bit 0 and zeros above it. Reading 0x40 + 16n or an unmapped address returns zero.
- R4: mbox_irq[n] is high exactly while mailbox n is nonzero and the enable of core n (control bit 0) is set. It changes on the same edge as the state that drives it.
- R5: If one port sets a bit and another port clears the same bit in the same cycle, the bit ends up set.
- R6: Sets from several ports to the same mailbox in one cycle are all kept (their data is ORed). Successive writes to different set addresses signal each core in turn.
- R7: A control write stores only data bit 0 as the enable. When several ports write the same control register in one cycle, the lowest-numbered port wins.
- R8: Reset (rst high at a clock edge) clears every mailbox, every enable and every interrupt.
- R9: A write to an address outside the three windows changes no mailbox and no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NUM_PORTS | Write strobe, one per requester port |
| wr_addr | input | NUM_PORTS*ADDR_W | Byte address of each port; port p uses bits [p*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_PORTS*DATA_W | Write data of each port; port p uses bits [p*DATA_W +: DATA_W] |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Registered read data |
| mbox_irq | output | NUM_CORES | Per-core mailbox interrupt, registered |

## Verification
The bench sets and clears the same bit from two ports in one cycle. A design that gives clear the priority would drop that doorbell and leave the mailbox empty. It rings one mailbox from three ports at once. Logic that lets only one port win would lose bits. It reads the set window and an address next to it. A decoder that masks low address bits would return mailbox contents or corrupt a mailbox on a stray write. It also toggles the enable with a value whose bit 0 is clear but upper bits are set, and races two control writes. This exposes an enable taken from the wrong bit or the wrong port priority, and an interrupt that ignores the enable or lags a cycle behind the mailbox.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Spacing between per-core mailboxes and per-core control words (bytes)
  localparam int unsigned MB_STRIDE  = 16;
  localparam int unsigned CTL_STRIDE = 4;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_CTL  = 2'd1,
    HIT_SET  = 2'd2,
    HIT_CLR  = 2'd3
  } hit_kind_e;
endpackage

// File: rtl/mbox_addr_dec.sv
module mbox_addr_dec
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CTL_BASE  = 'h00,
  parameter int unsigned SET_BASE  = 'h40,
  parameter int unsigned CLR_BASE  = 'h80,
  localparam int unsigned IDX_W    = (NUM_CORES < 2) ? 1 : $clog2(NUM_CORES)
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    kind = HIT_NONE;
    idx  = '0;
    for (int n = 0; n < NUM_CORES; n++) begin
      if (addr == ADDR_W'(CTL_BASE + CTL_STRIDE * n)) begin
        kind = HIT_CTL;
        idx  = IDX_W'(n);
      end
      if (addr == ADDR_W'(SET_BASE + MB_STRIDE * n)) begin
        kind = HIT_SET;
        idx  = IDX_W'(n);
      end
      if (addr == ADDR_W'(CLR_BASE + MB_STRIDE * n)) begin
        kind = HIT_CLR;
        idx  = IDX_W'(n);
      end
    end
  end
endmodule

// File: rtl/mbox_wr_merge.sv
module mbox_wr_merge
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CTL_BASE  = 'h00,
  parameter int unsigned SET_BASE  = 'h40,
  parameter int unsigned CLR_BASE  = 'h80,
  localparam int unsigned IDX_W    = (NUM_CORES < 2) ? 1 : $clog2(NUM_CORES)
) (
  input  logic [NUM_PORTS-1:0]                  wr_en,
  input  logic [NUM_PORTS*ADDR_W-1:0]           wr_addr,
  input  logic [NUM_PORTS*DATA_W-1:0]           wr_data,
  output logic [NUM_CORES-1:0][DATA_W-1:0]      set_mask,
  output logic [NUM_CORES-1:0][DATA_W-1:0]      clr_mask,
  output logic [NUM_CORES-1:0]                  ctl_we,
  output logic [NUM_CORES-1:0]                  ctl_bit
);
  hit_kind_e        port_kind [NUM_PORTS];
  logic [IDX_W-1:0] port_idx  [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    mbox_addr_dec #(
      .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W),
      .CTL_BASE(CTL_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_dec (
      .addr(wr_addr[p*ADDR_W +: ADDR_W]),
      .kind(port_kind[p]),
      .idx (port_idx[p])
    );
  end

  for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
    always_comb begin
      set_mask[n] = '0;
      clr_mask[n] = '0;
      ctl_we[n]   = 1'b0;
      ctl_bit[n]  = 1'b0;
      // descending scan: the lowest-numbered port is applied last and wins
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
        if (wr_en[p] && port_idx[p] == IDX_W'(n)) begin
          case (port_kind[p])
            HIT_SET: set_mask[n] = set_mask[n] | wr_data[p*DATA_W +: DATA_W];
            HIT_CLR: clr_mask[n] = clr_mask[n] | wr_data[p*DATA_W +: DATA_W];
            HIT_CTL: begin
              ctl_we[n]  = 1'b1;
              ctl_bit[n] = wr_data[p*DATA_W];
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  input  logic              ctl_we,
  input  logic              ctl_bit,
  output logic [DATA_W-1:0] mb_q,
  output logic              en_q,
  output logic              irq_q
);
  logic [DATA_W-1:0] mb_d;
  logic              en_d;

  // clear first, then set: a doorbell rung in the same cycle survives
  assign mb_d = (mb_q & ~clr_mask) | set_mask;
  assign en_d = ctl_we ? ctl_bit : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mb_q  <= '0;
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      mb_q  <= mb_d;
      en_q  <= en_d;
      irq_q <= (|mb_d) & en_d;
    end
  end
endmodule

// File: rtl/mbox_rd_port.sv
module mbox_rd_port
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CTL_BASE  = 'h00,
  parameter int unsigned SET_BASE  = 'h40,
  parameter int unsigned CLR_BASE  = 'h80,
  localparam int unsigned IDX_W    = (NUM_CORES < 2) ? 1 : $clog2(NUM_CORES)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic [NUM_CORES-1:0][DATA_W-1:0] mb_q,
  input  logic [NUM_CORES-1:0]             en_q,
  output logic [DATA_W-1:0]                rd_data
);
  hit_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sel;

  mbox_addr_dec #(
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W),
    .CTL_BASE(CTL_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_dec (
    .addr(rd_addr),
    .kind(kind),
    .idx (idx)
  );

  always_comb begin
    sel = '0;
    for (int n = 0; n < NUM_CORES; n++) begin
      if (idx == IDX_W'(n)) begin
        case (kind)
          HIT_CLR: sel = mb_q[n];
          HIT_CTL: sel = {{(DATA_W-1){1'b0}}, en_q[n]};
          default: sel = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel;
  end
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CTL_BASE  = 'h00,
  parameter int unsigned SET_BASE  = 'h40,
  parameter int unsigned CLR_BASE  = 'h80
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PORTS-1:0]          wr_en,
  input  logic [NUM_PORTS*ADDR_W-1:0]   wr_addr,
  input  logic [NUM_PORTS*DATA_W-1:0]   wr_data,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  output logic [NUM_CORES-1:0]          mbox_irq
);
  logic [NUM_CORES-1:0][DATA_W-1:0] set_mask;
  logic [NUM_CORES-1:0][DATA_W-1:0] clr_mask;
  logic [NUM_CORES-1:0]             ctl_we;
  logic [NUM_CORES-1:0]             ctl_bit;
  logic [NUM_CORES-1:0][DATA_W-1:0] mb_q;
  logic [NUM_CORES-1:0]             en_q;

  mbox_wr_merge #(
    .NUM_CORES(NUM_CORES), .NUM_PORTS(NUM_PORTS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTL_BASE(CTL_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_merge (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .set_mask(set_mask),
    .clr_mask(clr_mask),
    .ctl_we  (ctl_we),
    .ctl_bit (ctl_bit)
  );

  for (genvar n = 0; n < NUM_CORES; n++) begin : g_slot
    mbox_slot #(.DATA_W(DATA_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .set_mask(set_mask[n]),
      .clr_mask(clr_mask[n]),
      .ctl_we  (ctl_we[n]),
      .ctl_bit (ctl_bit[n]),
      .mb_q    (mb_q[n]),
      .en_q    (en_q[n]),
      .irq_q   (mbox_irq[n])
    );
  end

  mbox_rd_port #(
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTL_BASE(CTL_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .mb_q   (mb_q),
    .en_q   (en_q),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/mbox_doorbell_chk.sv
module mbox_doorbell_chk
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SET_BASE  = 'h40,
  parameter int unsigned CLR_BASE  = 'h80
) (
  input logic                             clk,
  input logic                             rst,
  input logic [NUM_PORTS-1:0]             wr_en,
  input logic [NUM_PORTS*ADDR_W-1:0]      wr_addr,
  input logic [NUM_PORTS*DATA_W-1:0]      wr_data,
  input logic [NUM_CORES-1:0]             mbox_irq,
  input logic [NUM_CORES-1:0][DATA_W-1:0] mb_q,
  input logic [NUM_CORES-1:0]             en_q
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  logic [NUM_CORES-1:0][DATA_W-1:0] set_or;
  logic [NUM_CORES-1:0]             clr_hit;

  always_comb begin
    set_or  = '0;
    clr_hit = '0;
    for (int n = 0; n < NUM_CORES; n++) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (wr_en[p] && wr_addr[p*ADDR_W +: ADDR_W] == ADDR_W'(SET_BASE + MB_STRIDE * n))
          set_or[n] = set_or[n] | wr_data[p*DATA_W +: DATA_W];
        if (wr_en[p] && wr_addr[p*ADDR_W +: ADDR_W] == ADDR_W'(CLR_BASE + MB_STRIDE * n))
          clr_hit[n] = 1'b1;
      end
    end
  end

  // R8: state empty on the first edge after reset
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mb_q == '0 && en_q == '0 && mbox_irq == '0));

  for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
    // R4
    a_r4_irq_tracks: assert property (@(posedge clk) disable iff (rst)
      armed |-> (mbox_irq[n] == ((|mb_q[n]) && en_q[n])));
    // R5, R6: every bit rung last cycle is present now
    a_r5_set_lands: assert property (@(posedge clk) disable iff (rst)
      armed |-> ((mb_q[n] & $past(set_or[n])) == $past(set_or[n])));
    // R2: bits only fall through the clear window
    a_r2_drop_needs_clear: assert property (@(posedge clk) disable iff (rst)
      (armed && (|($past(mb_q[n]) & ~mb_q[n]))) |-> $past(clr_hit[n]));
    // R1: bits only rise through the set window
    a_r1_rise_needs_set: assert property (@(posedge clk) disable iff (rst)
      (armed && (|(~$past(mb_q[n]) & mb_q[n]))) |-> (|$past(set_or[n])));
  end
endmodule

bind mbox_doorbell mbox_doorbell_chk #(
  .NUM_CORES(NUM_CORES), .NUM_PORTS(NUM_PORTS),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .mbox_irq(mbox_irq),
  .mb_q    (mb_q),
  .en_q    (en_q)
);

// File: tb/sim_mbox_doorbell.sv
`timescale 1ns/1ps
module sim_mbox_doorbell;
  localparam int NC = 4;
  localparam int NP = 4;
  localparam int AW = 8;
  localparam int DW = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NP-1:0]     wr_en = '0;
  logic [NP*AW-1:0]  wr_addr = '0;
  logic [NP*DW-1:0]  wr_data = '0;
  logic              rd_en = 1'b0;
  logic [AW-1:0]     rd_addr = '0;
  logic [DW-1:0]     rd_data;
  logic [NC-1:0]     mbox_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  mbox_doorbell u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .mbox_irq(mbox_irq)
  );

  function automatic logic [AW-1:0] a_ctl(int n); return AW'('h00 + 4*n);  endfunction
  function automatic logic [AW-1:0] a_set(int n); return AW'('h40 + 16*n); endfunction
  function automatic logic [AW-1:0] a_clr(int n); return AW'('h80 + 16*n); endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic stage(int p, logic [AW-1:0] a, logic [DW-1:0] d);
    wr_en[p] = 1'b1;
    wr_addr[p*AW +: AW] = a;
    wr_data[p*DW +: DW] = d;
  endtask

  task automatic commit();
    @(negedge clk);
    wr_en = '0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic wr1(int p, logic [AW-1:0] a, logic [DW-1:0] d);
    stage(p, a, d);
    commit();
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    v = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R8 irq after reset", DW'(mbox_irq), '0);
    for (int n = 0; n < NC; n++) begin
      rd(a_clr(n), v); check("R8 mailbox after reset", v, '0);
      rd(a_ctl(n), v); check("R8 enable after reset", v, '0);
    end
  endtask

  task automatic t_set_clear();
    logic [DW-1:0] v;
    wr1(0, a_set(2), 32'h8000_0005);
    rd(a_clr(2), v); check("R1 set ORs bits", v, 32'h8000_0005);
    wr1(1, a_set(2), 32'h0000_0100);
    rd(a_clr(2), v); check("R1 second set keeps old bits", v, 32'h8000_0105);
    rd(a_clr(1), v); check("R1 other mailbox untouched", v, '0);
    rd(a_set(2), v); check("R3 set window reads zero", v, '0);
    wr1(2, a_clr(2), 32'h8000_0004);
    rd(a_clr(2), v); check("R2 clear drops only ones", v, 32'h0000_0101);
    wr1(2, a_clr(2), 32'hFFFF_FFFF);
    rd(a_clr(2), v); check("R2 clear all", v, '0);
  endtask

  task automatic t_irq();
    logic [DW-1:0] v;
    wr1(0, a_set(1), 32'h1);
    check("R4 no irq while disabled", DW'(mbox_irq), '0);
    wr1(1, a_ctl(1), 32'h1);
    check("R4 irq on enable", DW'(mbox_irq), 32'h2);
    rd(a_ctl(1), v); check("R3 ctl readback", v, 32'h1);
    wr1(1, a_clr(1), 32'h1);
    check("R4 irq drops with mailbox", DW'(mbox_irq), '0);
    wr1(3, a_set(1), 32'h4);
    check("R4 irq same edge as set", DW'(mbox_irq), 32'h2);
    wr1(1, a_ctl(1), 32'hFFFF_FFFE);
    check("R7 only bit0 enables", DW'(mbox_irq), '0);
    rd(a_ctl(1), v); check("R7 ctl reads bit0 only", v, '0);
    wr1(1, a_clr(1), 32'hFFFF_FFFF);
  endtask

  task automatic t_collision();
    logic [DW-1:0] v;
    wr1(0, a_set(3), 32'h0000_0001);
    stage(0, a_set(3), 32'h0000_0008);
    stage(1, a_clr(3), 32'h0000_0009);
    commit();
    rd(a_clr(3), v); check("R5 set wins over clear", v, 32'h0000_0008);
    wr1(0, a_clr(3), 32'hFFFF_FFFF);
  endtask

  task automatic t_multi();
    logic [DW-1:0] v;
    stage(0, a_set(0), 32'h0000_0001);
    stage(2, a_set(0), 32'h0001_0000);
    stage(3, a_set(0), 32'h8000_0000);
    commit();
    rd(a_clr(0), v); check("R6 same-cycle sets merge", v, 32'h8001_0001);
    wr1(0, a_clr(0), 32'hFFFF_FFFF);
    for (int n = 0; n < NC; n++) wr1(n, a_ctl(n), 32'h1);
    for (int n = 0; n < NC; n++) wr1(0, a_set(n), 32'h8000_0000);
    check("R6 all cores signalled in turn", DW'(mbox_irq), 32'hF);
    for (int n = 0; n < NC; n++) begin
      rd(a_clr(n), v); check("R6 per-core doorbell", v, 32'h8000_0000);
      wr1(n, a_clr(n), 32'hFFFF_FFFF);
    end
    check("R4 all irqs cleared", DW'(mbox_irq), '0);
  endtask

  task automatic t_ctl_prio();
    logic [DW-1:0] v;
    stage(3, a_ctl(3), 32'h0);
    stage(1, a_ctl(3), 32'h1);
    commit();
    rd(a_ctl(3), v); check("R7 lower port wins", v, 32'h1);
    stage(0, a_ctl(3), 32'h0);
    stage(2, a_ctl(3), 32'h1);
    commit();
    rd(a_ctl(3), v); check("R7 port0 wins", v, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] v;
    wr1(0, AW'('h44), 32'hFFFF_FFFF);
    wr1(1, AW'('h84), 32'hFFFF_FFFF);
    wr1(2, AW'('h02), 32'hFFFF_FFFF);
    wr1(3, AW'('hF0), 32'hFFFF_FFFF);
    check("R9 no irq from stray writes", DW'(mbox_irq), '0);
    for (int n = 0; n < NC; n++) begin
      rd(a_clr(n), v); check("R9 mailbox unchanged", v, '0);
    end
    rd(a_ctl(0), v); check("R9 enable unchanged", v, 32'h1);
    rd(AW'('h44), v); check("R3 unmapped reads zero", v, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_irq();
    t_collision();
    t_multi();
    t_ctl_prio();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule